// File: doc/BRIEF.md
# Display Window Pan Controller

This block keeps the start address of a 64-sample display window that slides over a 64K-sample capture memory. Two button levels, one for each direction, are sampled once per display frame when a single-cycle step strobe arrives. One button alone moves the window by a single sample. Both buttons together move it by a whole window width. The coarse move goes in whichever direction a single button last selected.

The window is clamped at both ends of memory. The low limit is address 0. The high limit is the last address at which a full window still fits, which is 0xFFC0 with the default parameters. A clear command sends the window back to address 0 when a new capture begins.

The stored direction is a two-state machine with states DIR_LEFT and DIR_RIGHT:
- A strobed left-only press takes it to DIR_LEFT.
- A strobed right-only press takes it to DIR_RIGHT.
- Every other condition holds the state, including a strobed press of both buttons.

A command decoder turns the inputs into one of five commands, which the address register then carries out: CMD_HOLD, CMD_FINE_DN, CMD_FINE_UP, CMD_COARSE and CMD_CLEAR.

Top module: `pan_window_ctrl`

## Requirements
- R1: After reset, `addr_o` is 0 and `dir_right_o` is 0 (left).
- R2: A strobe with only `left_i` high lowers `addr_o` by 1 on the next cycle and sets `dir_right_o` to 0.
- R3: A strobe with only `right_i` high raises `addr_o` by 1 on the next cycle and sets `dir_right_o` to 1.
- R4: A strobe with both buttons high moves `addr_o` by 64 in the stored direction (down when `dir_right_o`=0, up when 1) and leaves `dir_right_o` unchanged.
- R5: A downward move larger than the current address leaves `addr_o` at 0.
- R6: An upward move never goes past 0xFFC0. A coarse move that would overshoot stops at 0xFFC0, and a fine step at 0xFFC0 stays there.
- R7: A strobe with neither button high holds `addr_o` and `dir_right_o`.
- R8: With `step_i` low and `clear_i` low, the button inputs have no effect: `addr_o` and `dir_right_o` hold.
- R9: `clear_i` high sets `addr_o` to 0 on the next cycle, with or without a strobe. It takes priority over any button move and leaves `dir_right_o` unchanged.
- R10: `addr_o` never exceeds 0xFFC0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | One-cycle strobe, given once per frame |
| clear_i | input | 1 | Return the window to address 0 |
| left_i | input | 1 | Left button level, 1 = pressed |
| right_i | input | 1 | Right button level, 1 = pressed |
| addr_o | output | 16 | Registered window start address |
| dir_right_o | output | 1 | Stored direction, 1 = right |

## Verification
The properties assume the following about the inputs:
- The button and clear inputs are already debounced levels.
- Each is stable around the clock edge that samples it.
- `step_i` lasts a single cycle.

The bench drives every input on the falling edge. It raises the strobe for one cycle and then drops it together with `clear_i`, so each command is seen by exactly one rising edge. No property depends on how often the strobe arrives. Instead, the bench separates strobes with idle cycles in which held buttons must have no effect.

// File: rtl/pan_pkg.sv
package pan_pkg;

    typedef enum logic [2:0] {
        CMD_HOLD    = 3'd0,
        CMD_FINE_DN = 3'd1,
        CMD_FINE_UP = 3'd2,
        CMD_COARSE  = 3'd3,
        CMD_CLEAR   = 3'd4
    } pan_cmd_e;

    typedef enum logic {
        DIR_LEFT  = 1'b0,
        DIR_RIGHT = 1'b1
    } pan_dir_e;

endpackage

// File: rtl/pan_cmd_decode.sv
module pan_cmd_decode
    import pan_pkg::*;
(
    input  logic     step_i,
    input  logic     clear_i,
    input  logic     left_i,
    input  logic     right_i,
    output pan_cmd_e cmd_o
);

    always_comb begin
        if (clear_i) begin
            cmd_o = CMD_CLEAR;
        end else if (!step_i) begin
            cmd_o = CMD_HOLD;
        end else begin
            unique case ({left_i, right_i})
                2'b10:   cmd_o = CMD_FINE_DN;
                2'b01:   cmd_o = CMD_FINE_UP;
                2'b11:   cmd_o = CMD_COARSE;
                default: cmd_o = CMD_HOLD;
            endcase
        end
    end

endmodule

// File: rtl/pan_dir_fsm.sv
module pan_dir_fsm
    import pan_pkg::*;
(
    input  logic     clk_i,
    input  logic     rst_ni,
    input  pan_cmd_e cmd_i,
    output pan_dir_e dir_o,
    output logic     dir_right_o
);

    pan_dir_e state_q, state_d;

    // next-state logic
    always_comb begin
        state_d = state_q;
        unique case (cmd_i)
            CMD_FINE_DN: state_d = DIR_LEFT;
            CMD_FINE_UP: state_d = DIR_RIGHT;
            CMD_COARSE,
            CMD_CLEAR,
            CMD_HOLD:    state_d = state_q;
            default:     state_d = state_q;
        endcase
    end

    // state register
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= DIR_LEFT;
        end else begin
            state_q <= state_d;
        end
    end

    // outputs
    always_comb begin
        dir_o = state_q;
        unique case (state_q)
            DIR_RIGHT: dir_right_o = 1'b1;
            DIR_LEFT:  dir_right_o = 1'b0;
            default:   dir_right_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/pan_sat_step.sv
module pan_sat_step #(
    parameter int ADDR_W = 16,
    parameter int WIN    = 64
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [ADDR_W-1:0] amt_i,
    input  logic              up_i,
    output logic [ADDR_W-1:0] addr_o
);

    localparam logic [ADDR_W-1:0] ADDR_MAX = {ADDR_W{1'b1}} - ADDR_W'(WIN - 1);

    logic [ADDR_W:0] sum;

    always_comb begin
        sum = {1'b0, addr_i} + {1'b0, amt_i};
        if (up_i) begin
            addr_o = (sum > {1'b0, ADDR_MAX}) ? ADDR_MAX : sum[ADDR_W-1:0];
        end else begin
            addr_o = (addr_i < amt_i) ? '0 : (addr_i - amt_i);
        end
    end

endmodule

// File: rtl/pan_window_ctrl.sv
module pan_window_ctrl
    import pan_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int WIN    = 64
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              step_i,
    input  logic              clear_i,
    input  logic              left_i,
    input  logic              right_i,
    output logic [ADDR_W-1:0] addr_o,
    output logic              dir_right_o
);

    localparam logic [ADDR_W-1:0] AMT_FINE   = ADDR_W'(1);
    localparam logic [ADDR_W-1:0] AMT_COARSE = ADDR_W'(WIN);

    pan_cmd_e          cmd;
    pan_dir_e          dir;
    logic [ADDR_W-1:0] addr_q, addr_d, moved;
    logic [ADDR_W-1:0] amt;
    logic              up;

    pan_cmd_decode u_dec (
        .step_i (step_i),
        .clear_i(clear_i),
        .left_i (left_i),
        .right_i(right_i),
        .cmd_o  (cmd)
    );

    pan_dir_fsm u_dir (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .cmd_i      (cmd),
        .dir_o      (dir),
        .dir_right_o(dir_right_o)
    );

    // choose step size and sense
    always_comb begin
        amt = AMT_FINE;
        up  = 1'b0;
        unique case (cmd)
            CMD_FINE_DN: begin amt = AMT_FINE;   up = 1'b0;               end
            CMD_FINE_UP: begin amt = AMT_FINE;   up = 1'b1;               end
            CMD_COARSE:  begin amt = AMT_COARSE; up = (dir == DIR_RIGHT); end
            CMD_CLEAR,
            CMD_HOLD:    begin amt = AMT_FINE;   up = 1'b0;               end
            default:     begin amt = AMT_FINE;   up = 1'b0;               end
        endcase
    end

    pan_sat_step #(.ADDR_W(ADDR_W), .WIN(WIN)) u_step (
        .addr_i(addr_q),
        .amt_i (amt),
        .up_i  (up),
        .addr_o(moved)
    );

    always_comb begin
        unique case (cmd)
            CMD_CLEAR:   addr_d = '0;
            CMD_HOLD:    addr_d = addr_q;
            CMD_FINE_DN,
            CMD_FINE_UP,
            CMD_COARSE:  addr_d = moved;
            default:     addr_d = addr_q;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign addr_o = addr_q;

endmodule

// File: rtl/pan_window_chk.sv
module pan_window_chk #(
    parameter int ADDR_W = 16,
    parameter int WIN    = 64
) (
    input logic              clk_i,
    input logic              rst_ni,
    input logic              step_i,
    input logic              clear_i,
    input logic              left_i,
    input logic              right_i,
    input logic [ADDR_W-1:0] addr_o,
    input logic              dir_right_o
);

    localparam logic [ADDR_W-1:0] LIM = {ADDR_W{1'b1}} - ADDR_W'(WIN - 1);

    // R2
    assert_fine_left_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_i && !clear_i && left_i && !right_i |=>
            !dir_right_o &&
            addr_o == (($past(addr_o) == '0) ? '0 : $past(addr_o) - ADDR_W'(1)));

    // R3 and R6 (fine step up clamps at the limit)
    assert_fine_right_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_i && !clear_i && !left_i && right_i |=>
            dir_right_o &&
            addr_o == (($past(addr_o) == LIM) ? LIM : $past(addr_o) + ADDR_W'(1)));

    assert_coarse_keep_dir_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_i && !clear_i && left_i && right_i |=> $stable(dir_right_o));

    assert_idle_strobe_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        step_i && !clear_i && !left_i && !right_i |=>
            $stable(addr_o) && $stable(dir_right_o));

    assert_no_strobe_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !step_i && !clear_i |=> $stable(addr_o) && $stable(dir_right_o));

    assert_clear_zero_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        clear_i |=> addr_o == '0 && $stable(dir_right_o));

    assert_below_limit_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        addr_o <= LIM);

endmodule

bind pan_window_ctrl pan_window_chk #(.ADDR_W(ADDR_W), .WIN(WIN)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .step_i     (step_i),
    .clear_i    (clear_i),
    .left_i     (left_i),
    .right_i    (right_i),
    .addr_o     (addr_o),
    .dir_right_o(dir_right_o)
);

// File: tb/pan_window_ctrl_tb.sv
module pan_window_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step = 1'b0;
    logic        clr = 1'b0;
    logic        lft = 1'b0;
    logic        rgt = 1'b0;
    logic [15:0] addr;
    logic        dirr;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;  // 125 MHz

    pan_window_ctrl dut_i (
        .clk_i      (clk),
        .rst_ni     (rst_n),
        .step_i     (step),
        .clear_i    (clr),
        .left_i     (lft),
        .right_i    (rgt),
        .addr_o     (addr),
        .dir_right_o(dirr)
    );

    // {clear, left, right, expected addr, expected dir_right}
    localparam int NV = 14;
    localparam logic [19:0] VEC [NV] = '{
        {3'b001, 16'd1,   1'b1},  // R3
        {3'b001, 16'd2,   1'b1},  // R3
        {3'b010, 16'd1,   1'b0},  // R2
        {3'b011, 16'd0,   1'b0},  // R4 down, R5 underflow
        {3'b010, 16'd0,   1'b0},  // R5 left at 0
        {3'b001, 16'd1,   1'b1},  // R3
        {3'b011, 16'd65,  1'b1},  // R4 up
        {3'b011, 16'd129, 1'b1},  // R4 up
        {3'b000, 16'd129, 1'b1},  // R7
        {3'b010, 16'd128, 1'b0},  // R2
        {3'b011, 16'd64,  1'b0},  // R4 down
        {3'b011, 16'd0,   1'b0},  // R4 down to 0
        {3'b001, 16'd1,   1'b1},  // R3
        {3'b101, 16'd0,   1'b1}   // R9 priority, dir kept
    };

    task automatic check(input string req, input logic [15:0] ea, input logic ed);
        checks++;
        if (addr !== ea || dirr !== ed) begin
            fails++;
            $display("FAIL %s: addr=%h dir=%b expected addr=%h dir=%b", req, addr, dirr, ea, ed);
        end
    endtask

    // strobe once; outputs checked on the following falling edge
    task automatic strobe(input logic c, input logic l, input logic r);
        @(negedge clk);
        clr = c; lft = l; rgt = r; step = 1'b1;
        @(negedge clk);
        step = 1'b0; clr = 1'b0;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: run did not finish");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R1", 16'd0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", 16'd0, 1'b0);

        for (int i = 0; i < NV; i++) begin
            strobe(VEC[i][19], VEC[i][18], VEC[i][17]);
            check($sformatf("R2-vector %0d", i), VEC[i][16:1], VEC[i][0]);
        end

        // R8: buttons held, no strobe
        strobe(1'b0, 1'b0, 1'b1);
        check("R3", 16'd1, 1'b1);
        @(negedge clk);
        lft = 1'b1; rgt = 1'b1;
        repeat (5) @(negedge clk);
        check("R8", 16'd1, 1'b1);
        lft = 1'b1; rgt = 1'b0;
        repeat (3) @(negedge clk);
        check("R8", 16'd1, 1'b1);
        lft = 1'b0;

        // R6: walk up with coarse steps to the upper limit
        for (int k = 0; k < 1022; k++) strobe(1'b0, 1'b1, 1'b1);
        check("R4", 16'hFF81, 1'b1);
        strobe(1'b0, 1'b1, 1'b1);
        check("R6", 16'hFFC0, 1'b1);
        strobe(1'b0, 1'b1, 1'b1);
        check("R6", 16'hFFC0, 1'b1);
        strobe(1'b0, 1'b0, 1'b1);
        check("R6", 16'hFFC0, 1'b1);
        strobe(1'b0, 1'b1, 1'b0);
        check("R2", 16'hFFBF, 1'b0);
        strobe(1'b0, 1'b0, 1'b1);
        check("R10", 16'hFFC0, 1'b1);

        // R9: clear without strobe
        @(negedge clk);
        clr = 1'b1;
        @(negedge clk);
        clr = 1'b0;
        check("R9", 16'd0, 1'b1);

        // R1: reset mid-run
        strobe(1'b0, 1'b0, 1'b1);
        check("R3", 16'd1, 1'b1);
        rst_n = 1'b0;
        @(negedge clk);
        check("R1", 16'd0, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);

        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule